// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block produces a single CAS-before-RAS refresh cycle on the active-low row strobe (`ras_n`) and column strobe (`cas_n`) of an EDO DRAM each time it is asked. It runs from one timing clock at twice the memory-clock rate, so every edge it places falls on a half memory-clock boundary. Each interval is a count of timing-clock ticks ("halves"). The counts come from two 2-bit selects.

The precharge select `pre_sel` sets three things: how long RAS# stays high before it falls, how far ahead of RAS# the CAS# strobe falls, and so how long CAS# has been high before it falls. The pulse select `pw_sel` shortens the whole cycle. The pulse select alone sets the cycle length. The precharge select only moves the RAS# falling edge inside that length. Both selects are sampled once, when a cycle starts. A request that arrives during a cycle is held, and that cycle runs straight after the current one. A one-tick `done` pulse marks the tick in which RAS# goes high again.

Top module: `cbr_refresh_seq`

## Requirements
- R1: Counting ticks from the first tick after the start edge (tick 0), `ras_n` stays high for 4, 3 or 2 ticks for an effective precharge select of 0, 1 or 2. It then falls.
- R2: `ras_n` stays low for (6 - 2·w) + p ticks, where p is the effective precharge select and w the effective pulse select. A cycle therefore lasts 10 - 2·w ticks in total.
- R3: `cas_n` falls while `ras_n` is still high. It falls 2 ticks before `ras_n` when p = 1, and 1 tick before `ras_n` when p is 0 or 2.
- R4: `cas_n` rises (5 - 2·w) + p ticks after `ras_n` falls. This is one tick before `ras_n` rises, so `cas_n` never goes high while `ras_n` is high within a cycle.
- R5: A select value of 3 (binary 11) on either field gives exactly the same timing as 0.
- R6: While idle, a request sampled high starts a cycle at that edge. `busy` is high for exactly the ticks of the cycle.
- R7: `done` is high for one tick: the first tick after a cycle in which `ras_n` is high again. It is never high at any other time.
- R8: After reset, `ras_n` and `cas_n` are high, `busy` and `done` are low, and no cycle starts until a request arrives.
- R9: A request sampled while a cycle runs is held. Its cycle starts in the tick straight after the current cycle ends, and `busy` stays high between the two cycles. Only one such request is held. Further requests in the same cycle have no effect.
- R10: In back-to-back cycles, the high time of `cas_n` between its rise and its next fall is 4 ticks for p = 0 and 2 ticks for p = 1 or 2.
- R11: The selects are sampled only at the start edge of a cycle. Changing them during a cycle does not change that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Timing clock at twice the memory-clock rate; one tick is half a memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Refresh request, sampled on each rising edge |
| pre_sel | input | 2 | Precharge select: 0, 1, 2; 3 acts as 0 |
| pw_sel | input | 2 | Pulse select: 0, 1, 2; 3 acts as 0 |
| busy | output | 1 | High during the ticks of a refresh cycle |
| done | output | 1 | One-tick pulse when RAS# returns high |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |

## Verification
The hardest case to reach is a request held during a cycle, because the seam between two cycles is only visible then. It is the only place where the CAS# high time of R10 can be measured, and where R9's drop of an extra request can be seen. The stimulus raises `req` at fixed tick offsets inside a running cycle, one or two times, for random select pairs. It records every tick of `ras_n`, `cas_n`, `busy` and `done` over both cycles, and compares these bit masks with masks built from the tick formulas.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int HALF_W = 4;

  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    half_t ras_fall;
    half_t cas_fall;
    half_t cas_rise;
    half_t cyc_len;
  } cbr_timing_t;
endpackage

// File: rtl/cbr_interval_decode.sv
module cbr_interval_decode
  import cbr_pkg::*;
(
  input  logic [1:0]  pre_sel,
  input  logic [1:0]  pw_sel,
  output cbr_timing_t tim
);
  localparam int BASE_PRE  = 4;
  localparam int BASE_LEN  = 10;
  localparam int BASE_HOLD = 5;

  int p;
  int w;
  int setup;
  int hold;

  always_comb begin
    p     = (pre_sel == 2'b11) ? 0 : int'(pre_sel);
    w     = (pw_sel  == 2'b11) ? 0 : int'(pw_sel);
    setup = (p == 1) ? 2 : 1;
    hold  = BASE_HOLD - 2 * w + p;
    tim.ras_fall = half_t'(BASE_PRE - p);
    tim.cas_fall = half_t'(BASE_PRE - p - setup);
    tim.cas_rise = half_t'(BASE_PRE - p + hold);
    tim.cyc_len  = half_t'(BASE_LEN - 2 * w);
  end
endmodule

// File: rtl/cbr_rst_sync.sv
module cbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
  import cbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  cbr_timing_t tim_in,
  output logic        busy,
  output logic        done,
  output logic        ras_n,
  output logic        cas_n
);
  logic        act_q, act_d;
  logic        pend_q, pend_d;
  half_t       cnt_q, cnt_d;
  cbr_timing_t tim_q, tim_d;
  logic        ras_q, ras_d;
  logic        cas_q, cas_d;
  logic        done_q, done_d;
  logic        last, want, start;

  always_comb begin
    last  = act_q && (cnt_q == tim_q.cyc_len - half_t'(1));
    want  = req | pend_q;
    start = (!act_q && want) || (last && want);
    act_d = start ? 1'b1 : (last ? 1'b0 : act_q);
    if (start)      cnt_d = '0;
    else if (act_q) cnt_d = cnt_q + half_t'(1);
    else            cnt_d = '0;
    tim_d = start ? tim_in : tim_q;
    if (act_q && !last) pend_d = pend_q | req;
    else if (last)      pend_d = pend_q & req;
    else                pend_d = 1'b0;
    ras_d  = !(act_d && (cnt_d >= tim_d.ras_fall));
    cas_d  = !(act_d && (cnt_d >= tim_d.cas_fall) && (cnt_d < tim_d.cas_rise));
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      tim_q  <= '0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      if (start) tim_q <= tim_d;
      ras_q  <= ras_d;
      cas_q  <= cas_d;
      done_q <= done_d;
    end
  end

  assign busy  = act_q;
  assign done  = done_q;
  assign ras_n = ras_q;
  assign cas_n = cas_q;

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n);
  assert_cas_falls_high_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);
  assert_cas_rise_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> !ras_n);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_at_ras_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> done);
  assert_idle_strobes_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n));
  assert_cnt_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < tim_q.cyc_len));
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
  import cbr_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk2x,
  input  logic       rst_n,
  input  logic       req,
  input  logic [1:0] pre_sel,
  input  logic [1:0] pw_sel,
  output logic       busy,
  output logic       done,
  output logic       ras_n,
  output logic       cas_n
);
  logic        rst_sync_n;
  cbr_timing_t tim_in;

  cbr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk2x),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbr_interval_decode u_dec (
    .pre_sel (pre_sel),
    .pw_sel  (pw_sel),
    .tim     (tim_in)
  );

  cbr_seq u_seq (
    .clk    (clk2x),
    .rst_n  (rst_sync_n),
    .req    (req),
    .tim_in (tim_in),
    .busy   (busy),
    .done   (done),
    .ras_n  (ras_n),
    .cas_n  (cas_n)
  );
endmodule

// File: tb/cbr_refresh_seq_test.sv
module cbr_refresh_seq_test;
  logic       clk2x = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] pre_sel = 2'b00;
  logic [1:0] pw_sel = 2'b00;
  logic       busy, done, ras_n, cas_n;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_ras, m_cas, m_busy, m_done;

  cbr_refresh_seq uut (
    .clk2x(clk2x), .rst_n(rst_n), .req(req), .pre_sel(pre_sel), .pw_sel(pw_sel),
    .busy(busy), .done(done), .ras_n(ras_n), .cas_n(cas_n)
  );

  always #2 clk2x = ~clk2x;

  function automatic int eff(input logic [1:0] s);
    return (s == 2'b11) ? 0 : int'(s);
  endfunction
  function automatic int f_pre(input int p);  return 4 - p; endfunction
  function automatic int f_len(input int w);  return 10 - 2 * w; endfunction
  function automatic int f_su(input int p);   return (p == 1) ? 2 : 1; endfunction
  function automatic int f_hold(input int p, input int w); return 5 - 2 * w + p; endfunction

  // Masks over n ticks for ncyc back-to-back cycles with fixed selects
  function automatic logic [31:0] exp_ras(input int p, input int w, input int ncyc, input int n);
    logic [31:0] m = '1;
    for (int t = 0; t < n; t++)
      if (t < ncyc * f_len(w)) m[t] = ((t % f_len(w)) < f_pre(p));
    return m;
  endfunction
  function automatic logic [31:0] exp_cas(input int p, input int w, input int ncyc, input int n);
    logic [31:0] m = '1;
    for (int t = 0; t < n; t++) begin
      int tt = t % f_len(w);
      if (t < ncyc * f_len(w))
        m[t] = !((tt >= f_pre(p) - f_su(p)) && (tt < f_pre(p) + f_hold(p, w)));
    end
    return m;
  endfunction
  function automatic logic [31:0] exp_busy(input int w, input int ncyc, input int n);
    logic [31:0] m = '0;
    for (int t = 0; t < n; t++) m[t] = (t < ncyc * f_len(w));
    return m;
  endfunction
  function automatic logic [31:0] exp_done(input int w, input int ncyc, input int n);
    logic [31:0] m = '0;
    for (int k = 1; k <= ncyc; k++) if (k * f_len(w) < n) m[k * f_len(w)] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Optional start request, then n ticks; extra requests at ticks ra, rb;
  // selects changed to np/nw at tick tchg.
  task automatic capture(input bit go, input int n, input int ra, input int rb,
                         input logic [1:0] np, input logic [1:0] nw, input int tchg);
    m_ras = '1; m_cas = '1; m_busy = '0; m_done = '0;
    if (go) begin
      req = 1'b1;
      @(negedge clk2x);
    end
    for (int t = 0; t < n; t++) begin
      m_ras[t] = ras_n; m_cas[t] = cas_n; m_busy[t] = busy; m_done[t] = done;
      req = (t == ra) || (t == rb);
      if (t == tchg) begin pre_sel = np; pw_sel = nw; end
      @(negedge clk2x);
    end
    req = 1'b0;
  endtask

  task automatic check_all(input string rq, input int p, input int w, input int ncyc, input int n);
    chk(rq, "ras_n", m_ras, exp_ras(p, w, ncyc, n));
    chk(rq, "cas_n", m_cas, exp_cas(p, w, ncyc, n));
    chk(rq, "busy", m_busy, exp_busy(w, ncyc, n));
    chk(rq, "done", m_done, exp_done(w, ncyc, n));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk2x);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    join_none

    void'($urandom(32'd5150));
    repeat (3) @(negedge clk2x);
    rst_n = 1'b1;
    repeat (3) @(negedge clk2x);

    // R8: reset state, and nothing starts without a request
    chk("R8", "reset strobes", {30'd0, ras_n, cas_n}, 32'd3);
    chk("R8", "reset busy/done", {30'd0, busy, done}, 32'd0);
    capture(1'b0, 16, -1, -1, 2'b00, 2'b00, -1);
    chk("R8", "idle ras_n", m_ras, '1);
    chk("R8", "idle busy", m_busy, '0);

    // R1 R2 R3 R4 R6 R7: all nine select pairs, single cycle
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < 3; w++) begin
        pre_sel = 2'(p); pw_sel = 2'(w);
        capture(1'b1, 14, -1, -1, 2'b00, 2'b00, -1);
        check_all("R1/R2/R3/R4/R6/R7", p, w, 1, 14);
        repeat (2) @(negedge clk2x);
      end

    // R5: reserved code 11 on either field behaves as 00
    pre_sel = 2'b11; pw_sel = 2'b11;
    capture(1'b1, 14, -1, -1, 2'b00, 2'b00, -1);
    check_all("R5", 0, 0, 1, 14);
    pre_sel = 2'b11; pw_sel = 2'b10;
    capture(1'b1, 14, -1, -1, 2'b00, 2'b00, -1);
    check_all("R5", 0, 2, 1, 14);

    // R11: select change mid-cycle is ignored
    pre_sel = 2'b00; pw_sel = 2'b00;
    capture(1'b1, 14, -1, -1, 2'b10, 2'b10, 2);
    check_all("R11", 0, 0, 1, 14);

    // R9 R10: queued request runs back-to-back; a second extra request is dropped
    for (int p = 0; p < 3; p++) begin
      pre_sel = 2'(p); pw_sel = 2'b00;
      capture(1'b1, 26, 1, 4, 2'b00, 2'b00, -1);
      check_all("R9/R10", p, 0, 2, 26);
      repeat (2) @(negedge clk2x);
    end

    // Random select pairs, random single or queued cycles
    for (int i = 0; i < 40; i++) begin
      logic [1:0] rp = 2'($urandom_range(0, 3));
      logic [1:0] rw = 2'($urandom_range(0, 3));
      int q = $urandom_range(0, 1);
      int n = (q == 1) ? 22 : 12;
      pre_sel = rp; pw_sel = rw;
      if (eff(rw) == 0) n = (q == 1) ? 24 : 12;
      capture(1'b1, n, (q == 1) ? int'($urandom_range(0, 4)) : -1, -1, 2'b00, 2'b00, -1);
      check_all("R2/R4/R9 random", eff(rp), eff(rw), q + 1, n);
      repeat (int'($urandom_range(1, 3))) @(negedge clk2x);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule